// File: doc/BRIEF.md
# Serial Upstream Frame Generator

This block builds the read-return frames that a memory buffer sends to the host over a bundle of parallel serial lanes. A frame lasts twelve bit-times across fourteen lanes (168 bits). It carries a 144-bit payload, which is two 72-bit memory beats, followed by a CRC. The frame has no header. The receiver tells the frame kinds apart only by the CRC.

A new frame begins only when the frame-start strobe is high. In that cycle the generator picks the content of the frame in priority order:
- a status reply, if a sync request is still waiting for one;
- otherwise the word offered on the valid/ready read-data interface;
- otherwise an idle frame, whose CRC is deliberately wrong.

In degraded mode one physical lane is taken out of service. The frame still carries all 144 payload bits on the thirteen remaining lanes. To make room, the CRC shrinks to 12 bits.

Top module: `ufg_upstream_framer`

## Requirements
- R1: After synchronous reset, and before the first frame_start, every lane drives 0, in_ready is 0 while frame_start is low, and no status reply is waiting.
- R2: When frame_start is sampled high at clock edge E, bit-time t (0..11) of the new frame appears on the lanes after edge E+t. If no new frame_start is sampled, every lane drives 0 from edge E+12 until the next frame.
- R3: in_ready is high only in a cycle where frame_start is high and no status reply is waiting. A word on in_data is taken only when in_valid and in_ready are both high, so at most one word is taken per frame, and that word becomes the frame payload.
- R4: The normal CRC has 24 bits. It is computed over payload bits 0 to 143, in that order. The register starts at all ones. For each bit, the feedback is crc[23] XOR the data bit; the register shifts left by one; if the feedback is 1 the register is XORed with 0x864CFB.
- R5: In normal mode, payload bit j is frame bit j and CRC bit j is frame bit 144+j. Frame bit i is sent on lane (i mod 14) at bit-time (i div 14).
- R6: When no status reply is waiting and in_valid is low at frame_start, the generator sends an idle frame. Its payload is all zero and its CRC is the bitwise inverse of the correct CRC of that zero payload. This applies in both modes.
- R7: Each sync_req pulse queues one status reply. At most 3 replies can wait; further pulses are dropped. A sync_req sampled in the same cycle as frame_start counts only from the next frame on. A status frame carries status_word, sampled at frame_start, with a correct CRC. It takes priority over read data.
- R8: fail_en and fail_idx are sampled at frame_start. With fail_en set, the frame holds the 144 payload bits followed by a 12-bit CRC, which sits at frame bits 144 to 155. That CRC uses the same procedure as R4, with polynomial 0x80F, a 12-bit register that starts at all ones, and feedback from bit 11. Frame bit i goes on logical lane (i mod 13) at bit-time (i div 13).
- R9: In degraded mode, logical lane k drives physical lane k if k is below fail_idx, and physical lane k+1 otherwise. The skipped physical lane drives 0. A fail_idx above 13 is treated as 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Frame boundary strobe: a new frame is loaded at this edge |
| in_valid | input | 1 | Read-data word available |
| in_ready | output | 1 | Word taken at this edge |
| in_data | input | 144 | Read-data word (two memory beats) |
| sync_req | input | 1 | One-cycle pulse per received sync frame |
| status_word | input | 144 | Payload for status replies |
| fail_en | input | 1 | Degraded (one lane removed) mode |
| fail_idx | input | 4 | Physical lane to skip in degraded mode |
| lanes | output | 14 | Serial lane outputs, one bit per lane per bit-time |

## Verification
in_ready is combinational and is checked shortly after the falling edge in the frame_start cycle. The frame content is fixed at the frame_start edge, so bit-time t is due after t+1 rising edges. The bench therefore samples all fourteen lanes at the falling edge that follows each of those twelve edges. It then checks, one falling edge later, that the lanes have returned to zero. The expected lane values come from bench functions that apply the CRC and lane-placement rules to the payload chosen by a bench model of the waiting status replies.

// File: rtl/ufg_pkg.sv
// Package: shared types for the upstream frame generator.
// Assumes: three frame kinds, decided once per frame at the frame-start edge.
package ufg_pkg;
    typedef enum logic [1:0] {
        KIND_IDLE   = 2'd0,
        KIND_DATA   = 2'd1,
        KIND_STATUS = 2'd2
    } frame_kind_e;
endpackage

// File: rtl/ufg_crc.sv
// Module: ufg_crc
// Computes a CRC over a DATA_W-bit word in one combinational pass.
// Bit 0 of the word is shifted in first, the register starts at INIT,
// and the feedback is taken from the register's top bit.
// Assumes: the width W is at least 2.
module ufg_crc #(
    parameter int          DATA_W = 144,
    parameter int          W      = 24,
    parameter logic [W-1:0] POLY  = '0,
    parameter logic [W-1:0] INIT  = '1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [W-1:0]      crc_o
);
    logic [W-1:0] acc;
    logic         fb;

    // Unrolled serial LFSR over the whole payload.
    always_comb begin
        acc = INIT;
        fb  = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            fb  = acc[W-1] ^ data_i[i];
            acc = {acc[W-2:0], 1'b0};
            if (fb) acc = acc ^ POLY;
        end
        crc_o = acc;
    end
endmodule

// File: rtl/ufg_frame_build.sv
// Module: ufg_frame_build
// Puts together one frame vector: the payload in the low bits, then either
// the full CRC (normal mode) or the short CRC (degraded mode). For an idle
// frame the payload is zero and the CRC is inverted.
// Assumes: DATA_W + CRC_W == LANES*BEATS and DATA_W + CRC_FO_W == (LANES-1)*BEATS.
module ufg_frame_build
    import ufg_pkg::*;
#(
    parameter int              DATA_W   = 144,
    parameter int              FRAME_W  = 168,
    parameter int              CRC_W    = 24,
    parameter int              CRC_FO_W = 12,
    parameter logic [CRC_W-1:0]    POLY_MAIN = 24'h864CFB,
    parameter logic [CRC_FO_W-1:0] POLY_FO   = 12'h80F
) (
    input  frame_kind_e        kind_i,
    input  logic [DATA_W-1:0]  payload_i,
    input  logic               fo_mode_i,
    output logic [FRAME_W-1:0] frame_o
);
    localparam int PAD_W = FRAME_W - DATA_W - CRC_FO_W;

    logic [DATA_W-1:0]   pay;
    logic [CRC_W-1:0]    crc_main;
    logic [CRC_FO_W-1:0] crc_fo;
    logic [CRC_W-1:0]    crc_main_eff;
    logic [CRC_FO_W-1:0] crc_fo_eff;

    // Idle frames carry a zero payload.
    always_comb pay = (kind_i == KIND_IDLE) ? '0 : payload_i;

    ufg_crc #(.DATA_W(DATA_W), .W(CRC_W), .POLY(POLY_MAIN), .INIT('1)) crc_main_i (
        .data_i (pay),
        .crc_o  (crc_main)
    );

    ufg_crc #(.DATA_W(DATA_W), .W(CRC_FO_W), .POLY(POLY_FO), .INIT('1)) crc_fo_i (
        .data_i (pay),
        .crc_o  (crc_fo)
    );

    // Corrupt the CRC on idle frames so the receiver drops them.
    always_comb begin
        crc_main_eff = (kind_i == KIND_IDLE) ? ~crc_main : crc_main;
        crc_fo_eff   = (kind_i == KIND_IDLE) ? ~crc_fo   : crc_fo;
    end

    // Choose the layout for the active lane count.
    always_comb begin
        if (fo_mode_i) frame_o = {{PAD_W{1'b0}}, crc_fo_eff, pay};
        else           frame_o = {crc_main_eff, pay};
    end
endmodule

// File: rtl/ufg_lane_map.sv
// Module: ufg_lane_map
// Sends the bits of the current bit-time of a stored frame out on the
// physical lanes. In normal mode frame bit t*LANES+p goes to lane p. In
// degraded mode the frame is spread over LANES-1 logical lanes, and the
// logical lanes skip the physical lane skip_i.
// Assumes: skip_i is already clamped to LANES-1 or below.
module ufg_lane_map #(
    parameter int LANES   = 14,
    parameter int BEATS   = 12,
    parameter int FRAME_W = LANES * BEATS,
    parameter int CNT_W   = 4,
    parameter int LIDX_W  = 4
) (
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   bit_t_i,
    input  logic               active_i,
    input  logic               fo_mode_i,
    input  logic [LIDX_W-1:0]  skip_i,
    output logic [LANES-1:0]   lanes_o
);
    for (genvar p = 0; p < LANES; p++) begin : g_lane
        localparam int P = p;
        // Pick the frame bit for physical lane p in this bit-time.
        always_comb begin
            int t;
            int sk;
            int k;
            t  = int'(bit_t_i);
            sk = int'(skip_i);
            k  = (P < sk) ? P : P - 1;
            if (!active_i)        lanes_o[p] = 1'b0;
            else if (!fo_mode_i)  lanes_o[p] = frame_i[t*LANES + P];
            else if (P == sk)     lanes_o[p] = 1'b0;
            else                  lanes_o[p] = frame_i[t*(LANES-1) + k];
        end
    end
endmodule

// File: rtl/ufg_upstream_framer.sv
// Module: ufg_upstream_framer (top)
// Upstream frame generator. At each frame_start it picks a status reply,
// a read-data word or an idle frame, builds the frame with its CRC, and
// then sends it out over BEATS bit-times. It also counts the status replies
// that are still waiting.
// Assumes: frame_start normally arrives every BEATS cycles; if it does not,
// the lanes go quiet once the current frame is finished.
module ufg_upstream_framer
    import ufg_pkg::*;
#(
    parameter int LANES    = 14,
    parameter int BEATS    = 12,
    parameter int DATA_W   = 144,
    parameter int CRC_W    = 24,
    parameter int CRC_FO_W = 12,
    parameter int PEND_MAX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              sync_req,
    input  logic [DATA_W-1:0] status_word,
    input  logic              fail_en,
    input  logic [3:0]        fail_idx,
    output logic [LANES-1:0]  lanes
);
    localparam int FRAME_W = LANES * BEATS;
    localparam int CNT_W   = $clog2(BEATS + 1);
    localparam int LIDX_W  = 4;
    localparam int PEND_W  = $clog2(PEND_MAX + 1);

    logic [CNT_W-1:0]   bit_t;
    logic               active_q;
    logic [PEND_W-1:0]  pend_q;
    frame_kind_e        kind_next, kind_q;
    logic [DATA_W-1:0]  payload_sel;
    logic [FRAME_W-1:0] frame_next, frame_q;
    logic               fo_q;
    logic [LIDX_W-1:0]  skip_next, skip_q;
    logic               serve;

    // Choose the content of the next frame in priority order.
    always_comb begin
        serve       = frame_start && (pend_q != '0);
        in_ready    = frame_start && (pend_q == '0);
        kind_next   = (pend_q != '0) ? KIND_STATUS : (in_valid ? KIND_DATA : KIND_IDLE);
        payload_sel = (pend_q != '0) ? status_word : in_data;
        skip_next   = (fail_idx > LIDX_W'(LANES-1)) ? LIDX_W'(LANES-1) : fail_idx;
    end

    ufg_frame_build #(
        .DATA_W(DATA_W), .FRAME_W(FRAME_W), .CRC_W(CRC_W), .CRC_FO_W(CRC_FO_W)
    ) build_i (
        .kind_i    (kind_next),
        .payload_i (payload_sel),
        .fo_mode_i (fail_en),
        .frame_o   (frame_next)
    );

    // Count the status replies still to send, with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            if (sync_req && !serve && pend_q != PEND_W'(PEND_MAX))
                pend_q <= pend_q + 1'b1;
            else if (serve && !sync_req)
                pend_q <= pend_q - 1'b1;
        end
    end

    // Load a frame at frame_start and step through its bit-times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_t    <= '0;
            active_q <= 1'b0;
            frame_q  <= '0;
            fo_q     <= 1'b0;
            skip_q   <= '0;
            kind_q   <= KIND_IDLE;
        end else if (frame_start) begin
            bit_t    <= '0;
            active_q <= 1'b1;
            frame_q  <= frame_next;
            fo_q     <= fail_en;
            skip_q   <= skip_next;
            kind_q   <= kind_next;
        end else if (active_q) begin
            if (bit_t == CNT_W'(BEATS-1)) active_q <= 1'b0;
            else                          bit_t    <= bit_t + 1'b1;
        end
    end

    ufg_lane_map #(
        .LANES(LANES), .BEATS(BEATS), .FRAME_W(FRAME_W), .CNT_W(CNT_W), .LIDX_W(LIDX_W)
    ) map_i (
        .frame_i   (frame_q),
        .bit_t_i   (bit_t),
        .active_i  (active_q),
        .fo_mode_i (fo_q),
        .skip_i    (skip_q),
        .lanes_o   (lanes)
    );

    // R2: a frame_start edge begins bit-time 0 of an active frame.
    assert_frame_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (active_q && bit_t == '0));

    // R2: a frame ends after its last bit-time unless a new one starts.
    assert_frame_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && bit_t == CNT_W'(BEATS-1) && !frame_start) |=> !active_q);

    // R1 / R2: no lane toggles outside a frame.
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (lanes == '0));

    // R3: an accepted word produces a data frame.
    assert_accept_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (kind_q == KIND_DATA));

    // R7: a waiting status reply wins the next frame.
    assert_status_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && pend_q != '0) |=> (kind_q == KIND_STATUS));

    // R7: a sync pulse outside a frame boundary adds one waiting reply.
    assert_sync_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && !frame_start && pend_q != PEND_W'(PEND_MAX)) |=>
        (pend_q == $past(pend_q) + 1'b1));
endmodule

// File: tb/ufg_upstream_framer_tb_top.sv
module ufg_upstream_framer_tb_top;
    localparam int LANES = 14;
    localparam int BEATS = 12;
    localparam int DW    = 144;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          sync_req = 1'b0;
    logic [DW-1:0] status_word = '0;
    logic          fail_en = 1'b0;
    logic [3:0]    fail_idx = '0;
    logic [LANES-1:0] lanes;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_pend = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ufg_upstream_framer dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .sync_req(sync_req), .status_word(status_word),
        .fail_en(fail_en), .fail_idx(fail_idx), .lanes(lanes)
    );

    // CRC as stated in R4 and R8: bit 0 first, register starts all ones.
    function automatic logic [23:0] crc24(input logic [DW-1:0] d);
        logic [23:0] c = '1;
        for (int i = 0; i < DW; i++) begin
            logic f = c[23] ^ d[i];
            c = c << 1;
            if (f) c = c ^ 24'h864CFB;
        end
        return c;
    endfunction

    function automatic logic [11:0] crc12(input logic [DW-1:0] d);
        logic [11:0] c = '1;
        for (int i = 0; i < DW; i++) begin
            logic f = c[11] ^ d[i];
            c = c << 1;
            if (f) c = c ^ 12'h80F;
        end
        return c;
    endfunction

    // Expected frame vector. kind: 0 idle, 1 data, 2 status (R5, R6, R8).
    function automatic logic [167:0] exp_frame(input int kind, input logic [DW-1:0] pay, input bit fo);
        logic [DW-1:0] p = (kind == 0) ? '0 : pay;
        logic [167:0] f = '0;
        f[DW-1:0] = p;
        if (fo) f[155:144] = (kind == 0) ? ~crc12(p) : crc12(p);
        else    f[167:144] = (kind == 0) ? ~crc24(p) : crc24(p);
        return f;
    endfunction

    // Expected lane value (R5, R8, R9).
    function automatic logic exp_lane(input logic [167:0] f, input bit fo, input int idx, input int p, input int t);
        int sk = (idx > 13) ? 13 : idx;
        if (!fo) return f[t*14 + p];
        if (p == sk) return 1'b0;
        return f[t*13 + ((p < sk) ? p : p - 1)];
    endfunction

    task automatic check(input bit ok, input string req, input logic [167:0] act, input logic [167:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        if (exp_pend < 3) exp_pend++;
    endtask

    // One frame: drive at a falling edge, then check all 12 bit-times and the tail.
    task automatic do_frame(input bit valid, input logic [DW-1:0] d, input bit fo, input int idx, input string req);
        int kind;
        logic [167:0] f;
        logic [DW-1:0] sw;
        bit ok;
        logic [167:0] act_t, exp_t;
        @(negedge clk);
        sw = {$urandom(), $urandom(), $urandom(), $urandom(), 16'($urandom())};
        frame_start = 1'b1; in_valid = valid; in_data = d;
        fail_en = fo; fail_idx = 4'(idx); status_word = sw;
        #1;
        kind = (exp_pend > 0) ? 2 : (valid ? 1 : 0);
        check(in_ready == (exp_pend == 0), "R3 ready at frame_start", {167'd0, in_ready}, {167'd0, exp_pend == 0});
        f = exp_frame(kind, (kind == 2) ? sw : d, fo);
        if (exp_pend > 0) exp_pend--;
        @(negedge clk);
        frame_start = 1'b0; in_valid = 1'b1;
        in_data = ~d; status_word = ~sw; fail_en = ~fo; fail_idx = 4'($urandom());
        ok = 1'b1; act_t = '0; exp_t = '0;
        for (int t = 0; t < BEATS; t++) begin
            if (t == 5) check(in_ready == 1'b0, "R3 no ready mid-frame", {167'd0, in_ready}, 168'd0);
            for (int p = 0; p < LANES; p++) begin
                if (lanes[p] !== exp_lane(f, fo, idx, p, t)) ok = 1'b0;
                act_t[t*14 + p] = lanes[p];
                exp_t[t*14 + p] = exp_lane(f, fo, idx, p, t);
            end
            @(negedge clk);
        end
        check(ok, req, act_t, exp_t);
        check(lanes == '0, "R2 lanes quiet after frame", {154'd0, lanes}, 168'd0);
        in_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom(), $urandom(), $urandom(), $urandom(), 16'($urandom())};
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int s;
        s = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        check(lanes == '0, "R1 lanes zero after reset", {154'd0, lanes}, 168'd0);
        check(in_ready == 1'b0, "R1 no ready without frame_start", {167'd0, in_ready}, 168'd0);
        // R6: idle frame, normal mode (inverted CRC of zero payload)
        do_frame(1'b0, rnd_word(), 1'b0, 0, "R6 idle normal");
        // R4 R5: data frames with distinct patterns
        do_frame(1'b1, '1, 1'b0, 0, "R4 R5 data all ones");
        do_frame(1'b1, {DW/2{2'b01}}, 1'b0, 0, "R4 R5 data alternating");
        do_frame(1'b1, rnd_word(), 1'b0, 0, "R4 R5 data random");
        // R7: five syncs saturate at three waiting replies, then data resumes
        repeat (5) pulse_sync();
        for (int i = 0; i < 4; i++) do_frame(1'b1, rnd_word(), 1'b0, 0, "R7 status priority and saturation");
        // R8 R9: degraded mode at edge skip indexes
        do_frame(1'b1, rnd_word(), 1'b1, 0, "R8 R9 skip lane 0");
        do_frame(1'b1, rnd_word(), 1'b1, 13, "R8 R9 skip lane 13");
        do_frame(1'b1, rnd_word(), 1'b1, 15, "R9 index clamp to 13");
        do_frame(1'b0, rnd_word(), 1'b1, 6, "R6 R8 idle degraded");
        pulse_sync();
        do_frame(1'b1, rnd_word(), 1'b1, 4, "R7 R8 status degraded");
        // Random mix
        for (int i = 0; i < 40; i++) begin
            int ns = $urandom_range(0, 2);
            for (int j = 0; j < ns; j++) if ($urandom_range(0, 3) == 0) pulse_sync();
            do_frame(1'($urandom()), rnd_word(), 1'($urandom()), $urandom_range(0, 15), "R3 R5 R7 R8 random");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule